// File: doc/BRIEF.md
# GPIO Interrupt Cause and Mask Unit

This block forms the interrupt side of a 32-line general-purpose I/O port. Each pin first passes through a two-stage synchronizer. A per-line polarity bit then decides whether the sampled level is kept or inverted. The result is the line's data-in value, and it feeds two independent interrupt paths.

The level path uses data-in directly as a live cause, and a level mask enables it per line. The edge path watches each data-in bit for a low-to-high change from one clock to the next. It records every such change in a sticky edge-cause register, and an edge mask enables that register per line. The two masked paths are ORed per line and gated by the line's direction bit, so only inputs can interrupt. The per-line results are then OR-reduced in groups of eight lines into one summary output per group.

Software reaches the direction, polarity, data-in, edge-cause and both mask registers through a flat single-cycle register port. A falling pin edge is caught by setting the polarity bit. Both edges can be caught by flipping the polarity after each event, since a polarity flip that raises data-in counts as an edge.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, the direction, polarity, edge-cause, edge-mask and level-mask registers read zero, and every group output is low.
- R2: Data-in (read at select 2) equals the pin value delayed by two clock edges, XORed with the current polarity register. A polarity bit of 1 inverts the line.
- R3: A line whose data-in bit is 1, with its level-mask bit set and its direction bit set (1 = input), drives its group output high for as long as those conditions hold.
- R4: When a data-in bit goes from 0 on one clock to 1 on the next, on a line configured as input, the line's edge-cause bit is set at that clock edge. It then stays set until software clears it.
- R5: A set edge-cause bit drives its group output only while the line's edge-mask bit is 1.
- R6: A write to the edge-cause register (select 3) clears every bit written as 0. Every bit written as 1 keeps its current value.
- R7: If a new rising transition of a line and a clearing write of that line's edge-cause bit fall on the same clock edge, the bit ends up set.
- R8: A write to the polarity register that takes a data-in bit from 0 to 1 counts as a rising transition and is latched into edge cause.
- R9: A line whose direction bit is 0 never sets its edge-cause bit and never drives a group output, whatever its masks and pin.
- R10: Group output g is the OR of the gated per-line causes of lines 8g to 8g+7. Four groups cover the 32 lines.
- R11: Register selects are 0 direction, 1 polarity, 2 data-in, 3 edge cause, 4 edge mask and 5 level mask. Data-in is read-only, and a write to it changes nothing. Selects 6 and 7 read zero. A write takes effect at the next clock edge, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| reg_sel | input | 3 | Register select for read and write |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| group_irq | output | 4 | One summary interrupt per eight-line group |

## Verification
Random pin activity runs against random mixes of direction, polarity and mask settings. This separates the live level path from the sticky edge path, because a level cause must fall with its pin while an edge cause must stay set. Random edge-cause writes with mostly-one data show that only the zero bits clear. Directed sequences fire a rising transition and a clearing write on the same clock edge, which tests whether the edge wins. They also flip the polarity of a steady line, which tests whether a polarity-made edge is latched. A line set as output that toggles with all masks open must leave both its group and its cause bit unchanged. Single lines driven in each group in turn expose any mistake in the group mapping.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIR    = 3'd0,
        SEL_POL    = 3'd1,
        SEL_DIN    = 3'd2,
        SEL_ECAUSE = 3'd3,
        SEL_EMASK  = 3'd4,
        SEL_LMASK  = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] data_in,
    input  logic [WIDTH-1:0] line_en,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] clr_keep,
    output logic [WIDTH-1:0] cause,
    output logic [WIDTH-1:0] rise
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic prev_q;
        logic cause_q;
        logic kept;

        assign rise[i] = data_in[i] & ~prev_q & line_en[i];
        assign kept    = clr_we ? (cause_q & clr_keep[i]) : cause_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q  <= 1'b0;
                cause_q <= 1'b0;
            end else begin
                prev_q  <= data_in[i];
                cause_q <= kept | rise[i];
            end
        end

        assign cause[i] = cause_q;
    end
endmodule

// File: rtl/gpio_group_reduce.sv
module gpio_group_reduce #(
    parameter int WIDTH      = 32,
    parameter int GROUP_SIZE = 8,
    localparam int NUM_GROUPS = WIDTH / GROUP_SIZE
) (
    input  logic [WIDTH-1:0]      line_cause,
    output logic [NUM_GROUPS-1:0] group_irq
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign group_irq[g] = |line_cause[g*GROUP_SIZE +: GROUP_SIZE];
    end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int GROUP_SIZE = 8,
    localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  pin_in,
    input  logic [SEL_W-1:0]      reg_sel,
    input  logic                  reg_we,
    input  logic [NUM_LINES-1:0]  reg_wdata,
    output logic [NUM_LINES-1:0]  reg_rdata,
    output logic [NUM_GROUPS-1:0] group_irq
);
    logic [NUM_LINES-1:0] dir_q;
    logic [NUM_LINES-1:0] pol_q;
    logic [NUM_LINES-1:0] emask_q;
    logic [NUM_LINES-1:0] lmask_q;
    logic [NUM_LINES-1:0] pin_sync;
    logic [NUM_LINES-1:0] data_in;
    logic [NUM_LINES-1:0] ecause;
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] line_cause;
    logic                 ecause_we;

    gpio_sync #(.WIDTH(NUM_LINES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    assign data_in   = pin_sync ^ pol_q;
    assign ecause_we = reg_we && (reg_sel == SEL_ECAUSE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            pol_q   <= '0;
            emask_q <= '0;
            lmask_q <= '0;
        end else if (reg_we) begin
            case (reg_sel)
                SEL_DIR:   dir_q   <= reg_wdata;
                SEL_POL:   pol_q   <= reg_wdata;
                SEL_EMASK: emask_q <= reg_wdata;
                SEL_LMASK: lmask_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    gpio_edge_cause #(.WIDTH(NUM_LINES)) i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_in  (data_in),
        .line_en  (dir_q),
        .clr_we   (ecause_we),
        .clr_keep (reg_wdata),
        .cause    (ecause),
        .rise     (rise)
    );

    assign line_cause = ((data_in & lmask_q) | (ecause & emask_q)) & dir_q;

    gpio_group_reduce #(.WIDTH(NUM_LINES), .GROUP_SIZE(GROUP_SIZE)) i_group (
        .line_cause (line_cause),
        .group_irq  (group_irq)
    );

    always_comb begin
        case (reg_sel)
            SEL_DIR:    reg_rdata = dir_q;
            SEL_POL:    reg_rdata = pol_q;
            SEL_DIN:    reg_rdata = data_in;
            SEL_ECAUSE: reg_rdata = ecause;
            SEL_EMASK:  reg_rdata = emask_q;
            SEL_LMASK:  reg_rdata = lmask_q;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker #(
    parameter int NUM_LINES  = 32,
    parameter int NUM_GROUPS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ecause_we,
    input logic [NUM_LINES-1:0]  dir,
    input logic [NUM_LINES-1:0]  lmask,
    input logic [NUM_LINES-1:0]  din,
    input logic [NUM_LINES-1:0]  ecause,
    input logic [NUM_LINES-1:0]  rise,
    input logic [NUM_GROUPS-1:0] group_irq
);
    // R9: no input lines, no group output
    a_r9_outputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == '0) |-> (group_irq == '0));

    // R9: a cause bit only appears on a line that was an input
    a_r9_no_latch_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        ((ecause & ~$past(ecause) & ~$past(dir)) == '0));

    // R4: without a clearing write, cause bits never drop
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !ecause_we |=> ((ecause & $past(ecause)) == $past(ecause)));

    // R7: a rising transition survives a simultaneous clear
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((ecause & $past(rise)) == $past(rise)));

    // R3: a live masked level on an input line raises some group
    a_r3_level_drives: assert property (@(posedge clk) disable iff (!rst_n)
        ((din & lmask & dir) != '0) |-> (group_irq != '0));
endmodule

bind gpio_irq_unit gpio_irq_checker #(.NUM_LINES(NUM_LINES), .NUM_GROUPS(NUM_GROUPS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ecause_we (ecause_we),
    .dir       (dir_q),
    .lmask     (lmask_q),
    .din       (data_in),
    .ecause    (ecause),
    .rise      (rise),
    .group_irq (group_irq)
);

// File: tb/test_gpio_irq_unit.sv
`timescale 1ns/1ps
module test_gpio_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic [2:0]  reg_sel = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  group_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference state
    logic [31:0] m_s1, m_s2, m_pol, m_dir, m_em, m_lm, m_ec, m_dq;

    always #10 clk = ~clk;

    gpio_irq_unit i_gpio_irq_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .group_irq (group_irq)
    );

    function automatic logic [31:0] m_din();
        return m_s2 ^ m_pol;
    endfunction

    function automatic logic [3:0] m_groups();
        logic [31:0] c;
        logic [3:0]  g;
        c = ((m_din() & m_lm) | (m_ec & m_em)) & m_dir;
        for (int k = 0; k < 4; k++) g[k] = |c[k*8 +: 8];
        return g;
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] s);
        case (s)
            3'd0: return m_dir;
            3'd1: return m_pol;
            3'd2: return m_din();
            3'd3: return m_ec;
            3'd4: return m_em;
            3'd5: return m_lm;
            default: return '0;
        endcase
    endfunction

    task automatic m_reset();
        m_s1 = '0; m_s2 = '0; m_pol = '0; m_dir = '0;
        m_em = '0; m_lm = '0; m_ec = '0; m_dq = '0;
    endtask

    task automatic m_step();
        logic [31:0] d, r, ec;
        d  = m_din();
        r  = d & ~m_dq & m_dir;
        ec = m_ec;
        if (reg_we) begin
            case (reg_sel)
                3'd0: m_dir = reg_wdata;
                3'd1: m_pol = reg_wdata;
                3'd3: ec = ec & reg_wdata;
                3'd4: m_em = reg_wdata;
                3'd5: m_lm = reg_wdata;
                default: ;
            endcase
        end
        m_ec = ec | r;
        m_dq = d;
        m_s2 = m_s1;
        m_s1 = pin_in;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock edge, with the reference stepped; returns at the falling edge
    task automatic cycle();
        @(posedge clk);
        #1 m_step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] v);
        reg_sel = s; reg_we = 1'b1; reg_wdata = v;
        cycle();
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] s, input logic [31:0] exp);
        reg_sel = s;
        #1 chk(tag, reg_rdata, exp);
    endtask

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 6; s++)
            if (s != 2) rd_chk("R1 reset reg", 3'(s), 32'h0);
        chk("R1 reset groups", {28'h0, group_irq}, 32'h0);

        // R2 synchronizer and polarity
        wr(3'd0, 32'hFFFF_FFFF);
        pin_in = 32'h0000_0008;
        cycle();
        rd_chk("R2 one edge, not yet", 3'd2, 32'h0);
        cycle();
        rd_chk("R2 two edges", 3'd2, 32'h0000_0008);
        rd_chk("R4 edge latched", 3'd3, 32'h0);
        cycle();
        rd_chk("R4 edge latched", 3'd3, 32'h0000_0008);

        // R5 edge mask gating
        chk("R5 unmasked edge quiet", {28'h0, group_irq}, 32'h0);
        wr(3'd4, 32'h0000_0008);
        chk("R5 masked edge drives", {28'h0, group_irq}, 32'h1);

        // R6 write one keeps, write zero clears
        wr(3'd3, 32'hFFFF_FFFF);
        rd_chk("R6 write one keeps", 3'd3, 32'h0000_0008);
        wr(3'd3, 32'hFFFF_FFF7);
        rd_chk("R6 write zero clears", 3'd3, 32'h0);
        chk("R6 group falls", {28'h0, group_irq}, 32'h0);

        // R3 level path and live tracking
        wr(3'd5, 32'h0000_0008);
        chk("R3 level drives", {28'h0, group_irq}, 32'h1);
        pin_in = 32'h0;
        cycle(); cycle();
        chk("R3 level follows pin", {28'h0, group_irq}, 32'h0);

        // R2 polarity inversion: low pin reads 1
        wr(3'd1, 32'h0000_0008);
        rd_chk("R2 polarity inverts", 3'd2, 32'h0000_0008);
        chk("R3 active-low level", {28'h0, group_irq}, 32'h1);
        // R8 polarity made edge latched one edge later
        cycle();
        rd_chk("R8 polarity edge latched", 3'd3, 32'h0000_0008);
        wr(3'd5, 32'h0);
        wr(3'd4, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd3, 32'h0);
        rd_chk("R6 cleared", 3'd3, 32'h0);

        // R7 edge and clear on the same edge: pin rises 2 edges before
        pin_in = 32'h0000_0100;
        cycle();
        reg_sel = 3'd3; reg_we = 1'b1; reg_wdata = 32'h0;
        cycle();   // data_in rises here; rise evaluated on next edge
        cycle();   // clearing write coincides with rise
        reg_we = 1'b0;
        rd_chk("R7 edge wins", 3'd3, 32'h0000_0100);
        wr(3'd3, 32'h0);
        pin_in = 32'h0; cycle(); cycle();

        // R9 output lines stay silent
        wr(3'd0, 32'hFFFF_FF00);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd5, 32'hFFFF_FFFF);
        pin_in = 32'h0000_00FF;
        cycle(); cycle(); cycle();
        rd_chk("R9 no cause on outputs", 3'd3, 32'h0);
        chk("R9 no group from outputs", {28'h0, group_irq}, 32'h0);
        pin_in = 32'h0;
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd5, 32'h0);
        wr(3'd4, 32'h0);
        cycle(); cycle();
        wr(3'd3, 32'h0);

        // R10 group mapping, one line per group in turn
        wr(3'd5, 32'hFFFF_FFFF);
        for (int g = 0; g < 4; g++) begin
            pin_in = 32'h1 << (g*8 + 7);
            cycle(); cycle();
            chk("R10 group map", {28'h0, group_irq}, 32'h1 << g);
        end
        pin_in = 32'h0; cycle(); cycle();

        // R11 data-in read-only, unused selects zero
        wr(3'd2, 32'hFFFF_FFFF);
        rd_chk("R11 data-in unwritten", 3'd2, 32'h0);
        rd_chk("R11 select 6 zero", 3'd6, 32'h0);
        rd_chk("R11 select 7 zero", 3'd7, 32'h0);

        // random mix against the reference model
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] rv;
            rv = $urandom;
            if (rv[3:0] < 4) pin_in = $urandom;
            else if (rv[3:0] < 7) pin_in = pin_in ^ (32'h1 << rv[8:4]);
            if (rv[12:10] == 0) begin
                reg_we = 1'b1;
                reg_sel = 3'($urandom_range(0, 7));
                reg_wdata = (reg_sel == 3'd3) ? ~(32'h1 << rv[20:16]) : $urandom;
            end else begin
                reg_we = 1'b0;
                reg_sel = 3'($urandom_range(0, 7));
            end
            cycle();
            reg_we = 1'b0;
            chk("R10 random groups", {28'h0, group_irq}, {28'h0, m_groups()});
            reg_sel = 3'($urandom_range(0, 7));
            #1 chk("R11 random read", reg_rdata, m_read(reg_sel));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule